// File: doc/BRIEF.md
# Watchdog Timer with Selectable Postscaler

This block guards a processor against runaway software. A base counter and an 8-bit postscaler advance on a dedicated watchdog clock that keeps running when the device clock is stopped for sleep. A 2-bit static mode field selects one of three time-out lengths: 1, 64 or 256 base periods. When the selected interval passes without a restart, the block raises a reset request for one watchdog-clock cycle and clears an active-low time-out flag. Software keeps the block quiet by issuing clear pulses more often than the shortest time-out. Entering sleep and waking on an interrupt also restart the count.

Mode code 00 turns off the reset function. In that mode the block acts as a plain 2^TMR_W overflow timer on the device clock. The timer stops advancing while the sleep level is high. An overflow only clears the flag, and a clear pulse sets the flag again. The clear, sleep-entry and wake pulses come from the device-clock domain. Each one reaches the watchdog domain through a toggle handshake into a two-flop synchroniser. A time-out crosses back to the flag the same way. The counters cannot be read or written: only the three pulses and reset act on them.

Watchdog-side states: WS_OFF (mode 00, counters held at zero), WS_COUNT (counting) and WS_FIRE (the one cycle that carries the reset request). Transitions: WS_OFF to WS_COUNT when the mode is not 00. WS_COUNT or WS_FIRE go to WS_FIRE on a tap hit with no restart. They go to WS_COUNT otherwise. Any state goes to WS_OFF in mode 00. Device-side states: DS_OFF (watchdog modes), DS_RUN (timer counting) and DS_PAUSE (sleep level high). DS_RUN and DS_PAUSE follow the sleep level. Either one goes to DS_OFF when the mode is not 00.

Top module: `wdog_post`

## Requirements
- R1: With mode 11, 10 or 01, the first reset request appears after exactly 2^BASE_W x {1, 64, 256} watchdog-clock edges counted from reset release. It repeats at the same interval.
- R2: Each reset request lasts exactly one watchdog-clock cycle.
- R3: In the watchdog modes, counting and reset requests continue while the device clock is stopped and the sleep level is high.
- R4: A clear pulse restarts the base counter and the postscaler. Clears spaced closer than the time-out prevent any reset request.
- R5: A sleep-entry pulse restarts the base counter and the postscaler in the same way as a clear.
- R6: A wake pulse restarts the base counter and the postscaler in the same way as a clear.
- R7: While reset is held, to_flag is 1 and rst_req is 0. A watchdog time-out drives to_flag to 0 within a few device-clock cycles.
- R8: In mode 00, rst_req is never asserted.
- R9: In mode 00, to_flag goes to 0 at the 2^TMR_W-th counting device-clock edge after reset release.
- R10: In mode 00, device-clock edges that see sleep_lvl high do not advance the timer.
- R11: In mode 00, a clear pulse sets to_flag to 1 at the next device-clock edge. It also restarts the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wd_clk | input | 1 | Free-running watchdog clock |
| dev_clk | input | 1 | Device clock; may stop during sleep |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cfg_mode | input | 2 | Static mode: 11 div1, 10 div64, 01 div256, 00 plain timer |
| clr_pulse | input | 1 | Clear command, one dev_clk cycle |
| sleep_pulse | input | 1 | Sleep-entry pulse, one dev_clk cycle |
| wake_pulse | input | 1 | Wake-on-interrupt pulse, one dev_clk cycle |
| sleep_lvl | input | 1 | High while the device sleeps |
| rst_req | output | 1 | Reset request, one wd_clk cycle |
| to_flag | output | 1 | Active-low time-out flag (dev_clk domain) |

## Verification
The bench sweeps the three postscaler taps and checks that the first and second requests land on the exact edge counts. A tap taken from the wrong postscaler bit, or an off-by-one in the base wrap, shifts those edges. Each restart source is driven on its own at a rate just above the time-out. A restart path that is missing or dropped in the synchroniser then produces a reset request. Stopping the device clock in sleep exposes a design that wrongly clocks the watchdog from it, because the requests would stop. In timer mode a 500-cycle sleep window must delay the overflow edge by exactly 500 cycles. A design that ignores the sleep level, raises rst_req, or fails to set the flag again on a clear is caught there.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER  = 2'b00,
        MODE_DIV256 = 2'b01,
        MODE_DIV64  = 2'b10,
        MODE_DIV1   = 2'b11
    } wd_mode_e;

    typedef enum logic [1:0] {
        WS_OFF,
        WS_COUNT,
        WS_FIRE
    } wd_state_e;

    typedef enum logic [1:0] {
        DS_OFF,
        DS_RUN,
        DS_PAUSE
    } dev_state_e;

    localparam int unsigned EVT_N    = 3;
    localparam int unsigned EVT_CLR  = 0;
    localparam int unsigned EVT_SLP  = 1;
    localparam int unsigned EVT_WAKE = 2;

endpackage

// File: rtl/wdog_pulse_sync.sv
module wdog_pulse_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);

    localparam int unsigned SH_W = STAGES + 1;

    logic            src_tgl_q;
    logic [SH_W-1:0] dst_sh_q;

    // source side: every pulse flips the level that crosses over
    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n)
            src_tgl_q <= 1'b0;
        else if (src_pulse)
            src_tgl_q <= ~src_tgl_q;
    end

    // destination side: synchroniser stages plus one history flop
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n)
            dst_sh_q <= '0;
        else
            dst_sh_q <= {dst_sh_q[SH_W-2:0], src_tgl_q};
    end

    assign dst_pulse = dst_sh_q[SH_W-1] ^ dst_sh_q[SH_W-2];

endmodule

// File: rtl/wdog_wd_core.sv
module wdog_wd_core
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_W   = 4,
    parameter int unsigned POST_W   = 8,
    parameter int unsigned MID_LOG2 = 6
) (
    input  logic             wd_clk,
    input  logic             rst_n,
    input  wd_mode_e         mode,
    input  logic [EVT_N-1:0] evt,
    output logic             fire
);

    logic [BASE_W-1:0] base_q;
    logic [POST_W-1:0] post_q;
    wd_state_e         st_q, st_d;
    logic              restart, base_wrap, tap_hit, off;

    assign restart   = |evt;
    assign base_wrap = &base_q;
    assign off       = (mode == MODE_TIMER);

    // 4-to-1 tap selection driven by the mode code
    always_comb begin
        unique case (mode)
            MODE_DIV1:   tap_hit = base_wrap;
            MODE_DIV64:  tap_hit = base_wrap && (&post_q[MID_LOG2-1:0]);
            MODE_DIV256: tap_hit = base_wrap && (&post_q);
            MODE_TIMER:  tap_hit = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WS_OFF:   st_d = (tap_hit && !restart) ? WS_FIRE : WS_COUNT;
            WS_COUNT: st_d = (tap_hit && !restart) ? WS_FIRE : WS_COUNT;
            WS_FIRE:  st_d = (tap_hit && !restart) ? WS_FIRE : WS_COUNT;
            default:  st_d = WS_OFF;
        endcase
        if (off)
            st_d = WS_OFF;
    end

    always_ff @(posedge wd_clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= WS_OFF;
        else
            st_q <= st_d;
    end

    always_ff @(posedge wd_clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            post_q <= '0;
        end else if (off || restart) begin
            base_q <= '0;
            post_q <= '0;
        end else begin
            base_q <= base_q + 1'b1;
            if (base_wrap)
                post_q <= post_q + 1'b1;
        end
    end

    always_comb begin
        fire = (st_q == WS_FIRE);
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge wd_clk) disable iff (!rst_n)
        fire |=> !fire); // R2
    AST_REQ_ON_WRAP: assert property (@(posedge wd_clk) disable iff (!rst_n)
        fire |-> (base_q == '0)); // R1
    AST_RESTART_ZEROES: assert property (@(posedge wd_clk) disable iff (!rst_n)
        (restart && !off) |=> (base_q == '0 && post_q == '0 && !fire)); // R4
    AST_TIMER_NO_REQ: assert property (@(posedge wd_clk) disable iff (!rst_n)
        off |=> !fire); // R8

endmodule

// File: rtl/wdog_dev_side.sv
module wdog_dev_side
    import wdog_pkg::*;
#(
    parameter int unsigned TMR_W = 16
) (
    input  logic             dev_clk,
    input  logic             rst_n,
    input  wd_mode_e         mode,
    input  logic             sleep_lvl,
    input  logic [EVT_N-1:0] evt,
    input  logic             wd_timeout,
    output logic             to_flag
);

    logic [TMR_W-1:0] tmr_q;
    dev_state_e       st_q, st_d;
    logic             flag_q, timer_mode, restart, ovf;

    assign timer_mode = (mode == MODE_TIMER);
    assign restart    = |evt;
    assign ovf        = timer_mode && (st_d == DS_RUN) && (&tmr_q) && !restart;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DS_OFF:   st_d = sleep_lvl ? DS_PAUSE : DS_RUN;
            DS_RUN:   st_d = sleep_lvl ? DS_PAUSE : DS_RUN;
            DS_PAUSE: st_d = sleep_lvl ? DS_PAUSE : DS_RUN;
            default:  st_d = DS_OFF;
        endcase
        if (!timer_mode)
            st_d = DS_OFF;
    end

    always_ff @(posedge dev_clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= DS_OFF;
        else
            st_q <= st_d;
    end

    always_ff @(posedge dev_clk or negedge rst_n) begin
        if (!rst_n)
            tmr_q <= '0;
        else if (!timer_mode || restart)
            tmr_q <= '0;
        else if (st_d == DS_RUN)
            tmr_q <= tmr_q + 1'b1;
    end

    always_ff @(posedge dev_clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b1;
        else if (timer_mode && evt[EVT_CLR])
            flag_q <= 1'b1;
        else if (ovf || wd_timeout)
            flag_q <= 1'b0;
    end

    always_comb begin
        to_flag = flag_q;
    end

    AST_PAUSE_HOLDS: assert property (@(posedge dev_clk) disable iff (!rst_n)
        (timer_mode && sleep_lvl && !restart) |=> $stable(tmr_q)); // R10
    AST_OVF_CLEARS_FLAG: assert property (@(posedge dev_clk) disable iff (!rst_n)
        (timer_mode && !sleep_lvl && (&tmr_q) && !restart) |=> !to_flag); // R9
    AST_CLR_SETS_FLAG: assert property (@(posedge dev_clk) disable iff (!rst_n)
        (timer_mode && evt[EVT_CLR]) |=> to_flag); // R11
    AST_TIMEOUT_FLAG: assert property (@(posedge dev_clk) disable iff (!rst_n)
        (wd_timeout && !(timer_mode && evt[EVT_CLR])) |=> !to_flag); // R7

endmodule

// File: rtl/wdog_post.sv
module wdog_post
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_W   = 4,
    parameter int unsigned POST_W   = 8,
    parameter int unsigned MID_LOG2 = 6,
    parameter int unsigned TMR_W    = 16
) (
    input  logic       wd_clk,
    input  logic       dev_clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode,
    input  logic       clr_pulse,
    input  logic       sleep_pulse,
    input  logic       wake_pulse,
    input  logic       sleep_lvl,
    output logic       rst_req,
    output logic       to_flag
);

    wd_mode_e         mode;
    logic [EVT_N-1:0] evt_dev, evt_wd;
    logic             fire, timeout_dev;

    assign mode              = wd_mode_e'(cfg_mode);
    assign evt_dev[EVT_CLR]  = clr_pulse;
    assign evt_dev[EVT_SLP]  = sleep_pulse;
    assign evt_dev[EVT_WAKE] = wake_pulse;

    for (genvar g = 0; g < EVT_N; g++) begin : g_evt_sync
        wdog_pulse_sync #(.STAGES(2)) sync_i (
            .src_clk   (dev_clk),
            .src_rst_n (rst_n),
            .src_pulse (evt_dev[g]),
            .dst_clk   (wd_clk),
            .dst_rst_n (rst_n),
            .dst_pulse (evt_wd[g])
        );
    end

    wdog_wd_core #(
        .BASE_W   (BASE_W),
        .POST_W   (POST_W),
        .MID_LOG2 (MID_LOG2)
    ) wd_core_i (
        .wd_clk (wd_clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .evt    (evt_wd),
        .fire   (fire)
    );

    wdog_pulse_sync #(.STAGES(2)) timeout_sync_i (
        .src_clk   (wd_clk),
        .src_rst_n (rst_n),
        .src_pulse (fire),
        .dst_clk   (dev_clk),
        .dst_rst_n (rst_n),
        .dst_pulse (timeout_dev)
    );

    wdog_dev_side #(.TMR_W(TMR_W)) dev_side_i (
        .dev_clk    (dev_clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .sleep_lvl  (sleep_lvl),
        .evt        (evt_dev),
        .wd_timeout (timeout_dev),
        .to_flag    (to_flag)
    );

    assign rst_req = fire;

endmodule

// File: tb/wdog_post_tb_top.sv
module wdog_post_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_PERIOD  = 14;
    localparam int BASE_W     = 4;
    localparam int TMR_W      = 16;
    localparam int BASE_TICKS = 1 << BASE_W;
    localparam int LIMIT      = 200000;

    logic       dev_clk = 1'b0, wd_clk = 1'b0, dev_run = 1'b1, rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'b11;
    logic       clr_pulse = 1'b0, sleep_pulse = 1'b0, wake_pulse = 1'b0, sleep_lvl = 1'b0;
    logic       rst_req, to_flag;

    int n_checks = 0, n_fail = 0;
    int wd_edges = 0, dev_edges = 0;
    int req_cnt = 0, first_req = 0, second_req = 0, width_err = 0;
    logic prev_req = 1'b0;
    bit done = 0;

    always #(CLK_PERIOD/2) if (dev_run) dev_clk = ~dev_clk;
    always #(WD_PERIOD/2) wd_clk = ~wd_clk;

    always @(posedge wd_clk) wd_edges <= rst_n ? wd_edges + 1 : 0;
    always @(posedge dev_clk) dev_edges <= rst_n ? dev_edges + 1 : 0;

    // request monitor, sampled on the falling watchdog edge
    always @(negedge wd_clk) begin
        if (!rst_n) begin
            req_cnt = 0; prev_req = 1'b0;
        end else begin
            if (rst_req) begin
                if (prev_req) width_err = width_err + 1;
                if (req_cnt == 0) first_req = wd_edges;
                if (req_cnt == 1) second_req = wd_edges;
                req_cnt = req_cnt + 1;
            end
            prev_req = rst_req;
        end
    end

    wdog_post #(.BASE_W(BASE_W), .TMR_W(TMR_W)) dut_i (
        .wd_clk(wd_clk), .dev_clk(dev_clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .clr_pulse(clr_pulse), .sleep_pulse(sleep_pulse), .wake_pulse(wake_pulse),
        .sleep_lvl(sleep_lvl), .rst_req(rst_req), .to_flag(to_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n = 1'b0; sleep_lvl = 1'b0; cfg_mode = m; dev_run = 1'b1;
        repeat (4) @(negedge dev_clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input int which);
        @(negedge dev_clk);
        if (which == 0) clr_pulse = 1'b1;
        if (which == 1) sleep_pulse = 1'b1;
        if (which == 2) wake_pulse = 1'b1;
        @(negedge dev_clk);
        clr_pulse = 1'b0; sleep_pulse = 1'b0; wake_pulse = 1'b0;
    endtask

    task automatic wait_dev(input int n);
        while (dev_edges < n) @(negedge dev_clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * LIMIT);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        // R7: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge dev_clk);
        check(to_flag === 1'b1, "R7 flag in reset", int'(to_flag), 1);
        check(rst_req === 1'b0, "R7 request in reset", int'(rst_req), 0);

        // R1: tap sweep with exact edge counts
        for (int t = 0; t < 3; t++) begin
            logic [1:0] m;
            int period;
            m      = (t == 0) ? 2'b11 : (t == 1) ? 2'b10 : 2'b01;
            period = BASE_TICKS * ((t == 0) ? 1 : (t == 1) ? 64 : 256);
            do_reset(m);
            if (t == 1) begin
                while (wd_edges < period / 2) @(negedge wd_clk);
                check(to_flag === 1'b1, "R7 flag before time-out", int'(to_flag), 1);
            end
            while (req_cnt < 1 && wd_edges < period + 20) @(negedge wd_clk);
            if (t == 0) begin
                repeat (8) @(negedge dev_clk);
                check(to_flag === 1'b0, "R7 flag after time-out", int'(to_flag), 0);
            end
            while (req_cnt < 2 && wd_edges < 2 * period + 20) @(negedge wd_clk);
            check(first_req == period, "R1 first request edge", first_req, period);
            check(second_req == 2 * period, "R1 second request edge", second_req, 2 * period);
        end
        check(width_err == 0, "R2 request width", width_err, 0);

        // R4 / R5 / R6: each restart source keeps the watchdog quiet
        for (int k = 0; k < 3; k++) begin
            string tag;
            tag = (k == 0) ? "R4 clear" : (k == 1) ? "R5 sleep entry" : "R6 wake";
            do_reset(2'b11);
            repeat (25) begin
                pulse(k);
                repeat (6) @(negedge dev_clk);
            end
            check(req_cnt == 0, {tag, " prevents request"}, req_cnt, 0);
            repeat (60) @(negedge wd_clk);
            check(req_cnt > 0, {tag, " then time-out resumes"}, req_cnt, 1);
        end

        // R3: watchdog runs with the device clock stopped
        do_reset(2'b11);
        pulse(1);
        sleep_lvl = 1'b1;
        @(negedge dev_clk);
        dev_run = 1'b0;
        begin
            int c0;
            c0 = req_cnt;
            repeat (50) @(negedge wd_clk);
            check(req_cnt - c0 >= 2, "R3 requests during sleep", req_cnt - c0, 3);
        end
        dev_run = 1'b1;
        sleep_lvl = 1'b0;

        // R8 / R9 / R10 / R11: plain timer mode
        do_reset(2'b00);
        wait_dev(1000);
        check(to_flag === 1'b1, "R9 flag before overflow", int'(to_flag), 1);
        sleep_lvl = 1'b1;
        wait_dev(1500);
        sleep_lvl = 1'b0;
        wait_dev((1 << TMR_W) + 499);
        check(to_flag === 1'b1, "R10 flag one edge before delayed overflow", int'(to_flag), 1);
        wait_dev((1 << TMR_W) + 500);
        check(to_flag === 1'b0, "R9 flag at overflow edge", int'(to_flag), 0);
        check(req_cnt == 0, "R8 no request in timer mode", req_cnt, 0);
        pulse(0);
        check(to_flag === 1'b1, "R11 clear sets flag", int'(to_flag), 1);
        repeat (100) @(negedge dev_clk);
        check(to_flag === 1'b1, "R11 timer restarted by clear", int'(to_flag), 1);

        done = 1;
        summary();
        $finish;
    end

endmodule